// File: doc/BRIEF.md
# Fast Wake Clock Restart Sequencer

This block returns a processor to full operation after a low-power pause. While the core sleeps in wait mode with all of its clocks stopped, a purely combinational gate watches a bank of active-low wake-up lines, each with its own enable bit. Any enabled line held low raises the fast start-up signal at once, with no clock involved. The signal then crosses into the sequencer's always-running clock domain through a synchronizer.

Once the synchronized trigger is seen, the sequencer restarts in a fixed order. First it turns on the fast internal RC oscillator. Next it waits for the oscillator's ready input and then points the master clock select at that oscillator. One cycle later it turns the processor clock back on. It then returns to its run state and stays there until software issues the next wait or idle command. A flag records whether the most recent wake-up came through the fast path.

In idle mode the master clock keeps running and only the processor clock is gated. A synchronized interrupt request, either normal or fast, turns the processor clock back on directly.

Top module: `frs_fast_restart`

## Requirements
- R1: `fast_start` is a combinational output that is high whenever at least one wake line `wake_n[i]` is low while its enable `wake_en[i]` is 1. Lines whose enable is 0 have no effect on it.
- R2: While and after reset, with no command given, `osc_en`=1, `mck_sel_fast`=1, `cpu_clk_en`=1 and `woke_fast`=0.
- R3: In the run state, a `wait_req` sampled high on a rising edge clears `cpu_clk_en`, `osc_en`, `mck_sel_fast` and `woke_fast` at that edge.
- R4: In wait mode, `osc_en` rises on the third rising edge after `fast_start` goes high. Two of those edges are synchronizer stages and one is the sequencer register.
- R5: After the oscillator is enabled, `mck_sel_fast` is set on the first rising edge that samples `osc_ready` high. It stays 0 while `osc_ready` is low.
- R6: `cpu_clk_en` is set on the rising edge after `mck_sel_fast` is set, and the sequencer is back in run.
- R7: `woke_fast` is set together with `osc_en` on a fast start-up. It is cleared by the next wait or idle entry. An exit from idle leaves it at 0.
- R8: In the run state, an `idle_req` sampled high clears only `cpu_clk_en`. `osc_en` and `mck_sel_fast` keep their values.
- R9: In idle, `cpu_clk_en` rises on the third rising edge after `irq` or `fiq` goes high. Wake lines have no effect in idle.
- R10: In run, wake triggers and interrupt requests change no output. In wait, `idle_req`, `wait_req` and interrupt requests change no output.
- R11: If `wait_req` and `idle_req` are both high in run, wait mode is entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running sequencer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wake_n | input | NUM_WAKE | Active-low wake-up lines, asynchronous |
| wake_en | input | NUM_WAKE | Per-line wake enable |
| wait_req | input | 1 | Command to enter wait mode |
| idle_req | input | 1 | Command to enter idle mode |
| irq | input | 1 | Interrupt request, asynchronous |
| fiq | input | 1 | Fast interrupt request, asynchronous |
| osc_ready | input | 1 | Fast RC oscillator is stable |
| fast_start | output | 1 | Combined asynchronous fast start-up signal |
| osc_en | output | 1 | Fast RC oscillator enable |
| mck_sel_fast | output | 1 | Master clock source select, 1 = fast RC |
| cpu_clk_en | output | 1 | Processor clock enable |
| woke_fast | output | 1 | Last wake-up used the fast start-up path |

## Verification
A sequencer stuck in the wrong state shows up at the clock-control outputs within one to three cycles of the stimulus that should have moved it. Examples are a processor clock that stays off, an oscillator enable that never rises, or a master clock that switches before ready. Skipped or extra synchronizer stages move the edge at which `osc_en` or `cpu_clk_en` rises, so every exit path is checked at its exact edge and one edge before it. States that must ignore stimulus are checked by holding triggers for several cycles and confirming that every output stays unchanged. After that, a legal exit is run to confirm the sequencer never left the state it was in.

// File: rtl/frs_pkg.sv
package frs_pkg;
   typedef enum logic [2:0] {
      ST_RUN    = 3'd0,
      ST_IDLE   = 3'd1,
      ST_WAIT   = 3'd2,
      ST_OSC    = 3'd3,
      ST_SWITCH = 3'd4
   } frs_state_e;
endpackage

// File: rtl/frs_wake_combine.sv
module frs_wake_combine #(
   parameter int NUM_WAKE = 16
) (
   input  logic [NUM_WAKE-1:0] wake_n,
   input  logic [NUM_WAKE-1:0] wake_en,
   output logic                fast_start
);
   logic [NUM_WAKE-1:0] hit;

   for (genvar g = 0; g < NUM_WAKE; g++) begin : g_line
      assign hit[g] = wake_en[g] & ~wake_n[g];
   end

   assign fast_start = |hit;
endmodule

// File: rtl/frs_sync.sv
module frs_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   logic [WIDTH-1:0] chain [STAGES];

   initial begin
      assert (STAGES >= 2) else $error("frs_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= '0;
      else        chain[0] <= din;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= '0;
         else        chain[s] <= chain[s-1];
      end
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/frs_seq.sv
module frs_seq
   import frs_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic trig_s,
   input  logic intr_s,
   input  logic wait_req,
   input  logic idle_req,
   input  logic osc_ready,
   output logic osc_en,
   output logic mck_sel_fast,
   output logic cpu_clk_en,
   output logic woke_fast
);
   frs_state_e state_q;
   logic osc_en_q, mck_fast_q, cpu_en_q, woke_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_RUN;
         osc_en_q   <= 1'b1;
         mck_fast_q <= 1'b1;
         cpu_en_q   <= 1'b1;
         woke_q     <= 1'b0;
      end else begin
         unique case (state_q)
            ST_RUN: begin
               if (wait_req) begin
                  state_q    <= ST_WAIT;
                  osc_en_q   <= 1'b0;
                  mck_fast_q <= 1'b0;
                  cpu_en_q   <= 1'b0;
                  woke_q     <= 1'b0;
               end else if (idle_req) begin
                  state_q  <= ST_IDLE;
                  cpu_en_q <= 1'b0;
                  woke_q   <= 1'b0;
               end
            end
            ST_IDLE: begin
               if (intr_s) begin
                  state_q  <= ST_RUN;
                  cpu_en_q <= 1'b1;
               end
            end
            ST_WAIT: begin
               if (trig_s) begin
                  state_q  <= ST_OSC;
                  osc_en_q <= 1'b1;
                  woke_q   <= 1'b1;
               end
            end
            ST_OSC: begin
               if (osc_ready) begin
                  state_q    <= ST_SWITCH;
                  mck_fast_q <= 1'b1;
               end
            end
            ST_SWITCH: begin
               state_q  <= ST_RUN;
               cpu_en_q <= 1'b1;
            end
            default: state_q <= ST_RUN;
         endcase
      end
   end

   assign osc_en       = osc_en_q;
   assign mck_sel_fast = mck_fast_q;
   assign cpu_clk_en   = cpu_en_q;
   assign woke_fast    = woke_q;

   // R4: oscillator restart only follows a synchronized trigger
   assert_osc_after_trig_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(osc_en_q) |-> $past(trig_s));

   // R5: master clock moves to the fast RC only once it is running and ready
   assert_mck_after_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mck_fast_q) |-> ($past(osc_ready) && osc_en_q));

   // R6 / R9: processor clock returns only after the switch or from idle
   assert_cpu_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_en_q) |-> (($past(state_q) == ST_SWITCH && mck_fast_q) ||
                           $past(state_q) == ST_IDLE));

   // R10: processor clock is on throughout run
   assert_run_cpu_on_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN) |-> cpu_en_q);

   // R7: fast wake flag only sets on leaving wait
   assert_woke_from_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(woke_q) |-> ($past(state_q) == ST_WAIT));
endmodule

// File: rtl/frs_fast_restart.sv
module frs_fast_restart #(
   parameter int NUM_WAKE    = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_WAKE-1:0] wake_n,
   input  logic [NUM_WAKE-1:0] wake_en,
   input  logic                wait_req,
   input  logic                idle_req,
   input  logic                irq,
   input  logic                fiq,
   input  logic                osc_ready,
   output logic                fast_start,
   output logic                osc_en,
   output logic                mck_sel_fast,
   output logic                cpu_clk_en,
   output logic                woke_fast
);
   localparam int SYNC_W = 2;

   initial begin
      assert (NUM_WAKE >= 1 && NUM_WAKE <= 64)
         else $error("frs_fast_restart: NUM_WAKE out of range");
      assert (SYNC_STAGES >= 2)
         else $error("frs_fast_restart: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_W-1:0] sync_in, sync_out;

   frs_wake_combine #(.NUM_WAKE(NUM_WAKE)) u_combine (
      .wake_n     (wake_n),
      .wake_en    (wake_en),
      .fast_start (fast_start)
   );

   assign sync_in = {irq | fiq, fast_start};

   frs_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (sync_in),
      .dout  (sync_out)
   );

   frs_seq u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .trig_s       (sync_out[0]),
      .intr_s       (sync_out[1]),
      .wait_req     (wait_req),
      .idle_req     (idle_req),
      .osc_ready    (osc_ready),
      .osc_en       (osc_en),
      .mck_sel_fast (mck_sel_fast),
      .cpu_clk_en   (cpu_clk_en),
      .woke_fast    (woke_fast)
   );
endmodule

// File: tb/frs_fast_restart_bench.sv
module frs_fast_restart_bench;
   localparam int NW = 16;

   logic clk = 1'b0;
   logic rst_n;
   logic [NW-1:0] wake_n, wake_en;
   logic wait_req, idle_req, irq, fiq, osc_ready;
   logic fast_start, osc_en, mck_sel_fast, cpu_clk_en, woke_fast;
   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   frs_fast_restart #(.NUM_WAKE(NW), .SYNC_STAGES(2)) u_frs_fast_restart (
      .clk(clk), .rst_n(rst_n), .wake_n(wake_n), .wake_en(wake_en),
      .wait_req(wait_req), .idle_req(idle_req), .irq(irq), .fiq(fiq),
      .osc_ready(osc_ready), .fast_start(fast_start), .osc_en(osc_en),
      .mck_sel_fast(mck_sel_fast), .cpu_clk_en(cpu_clk_en), .woke_fast(woke_fast)
   );

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic chk(input string req, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic chk_all(input string req, input logic o, input logic m,
                          input logic c, input logic w);
      chk({req, " osc_en"}, osc_en, o);
      chk({req, " mck_sel_fast"}, mck_sel_fast, m);
      chk({req, " cpu_clk_en"}, cpu_clk_en, c);
      chk({req, " woke_fast"}, woke_fast, w);
   endtask

   task automatic pulse_cmd(input logic w, input logic i);
      wait_req = w; idle_req = i;
      tick(1);
      wait_req = 0; idle_req = 0;
   endtask

   task automatic test_reset;
      chk_all("R2", 1, 1, 1, 0);
   endtask

   task automatic test_combine;
      wake_en = 16'h0004;
      wake_n[5] = 0; #1;
      chk("R1 disabled line", fast_start, 0);
      wake_n[2] = 0; #1;
      chk("R1 enabled line", fast_start, 1);
      wake_n = '1; #1;
      chk("R1 released", fast_start, 0);
      wake_en = 16'h8001;
      wake_n[15] = 0; #1;
      chk("R1 top line", fast_start, 1);
      wake_n = '1;
      tick(3);
   endtask

   task automatic test_run_ignore;
      wake_n[0] = 0; irq = 1;
      tick(5);
      chk_all("R10 run", 1, 1, 1, 0);
      wake_n = '1; irq = 0;
      tick(3);
   endtask

   task automatic test_wait_fast;
      osc_ready = 0;
      pulse_cmd(1, 0);
      chk_all("R3", 0, 0, 0, 0);
      wake_n[0] = 0;
      tick(2);
      chk("R4 early", osc_en, 0);
      tick(1);
      chk("R4 osc on", osc_en, 1);
      chk("R7 set", woke_fast, 1);
      tick(3);
      chk("R5 not ready", mck_sel_fast, 0);
      osc_ready = 1;
      tick(1);
      chk("R5 switched", mck_sel_fast, 1);
      chk("R6 not yet", cpu_clk_en, 0);
      tick(1);
      chk("R6 cpu on", cpu_clk_en, 1);
      wake_n = '1;
      tick(3);
      chk_all("R10 back in run", 1, 1, 1, 1);
   endtask

   task automatic test_wait_ignore;
      pulse_cmd(1, 0);
      chk("R7 cleared by wait", woke_fast, 0);
      idle_req = 1; irq = 1; fiq = 1;
      tick(5);
      idle_req = 0; irq = 0; fiq = 0;
      wait_req = 1; tick(1); wait_req = 0;
      tick(2);
      chk_all("R10 wait", 0, 0, 0, 0);
      wake_n[15] = 0;
      tick(3);
      chk("R4 second exit", osc_en, 1);
      tick(2);
      chk("R6 second exit", cpu_clk_en, 1);
      wake_n = '1;
      tick(3);
   endtask

   task automatic test_idle(input logic use_fiq);
      pulse_cmd(0, 1);
      chk_all("R8", 1, 1, 0, 0);
      wake_n[0] = 0;
      tick(5);
      chk("R9 wake ignored", cpu_clk_en, 0);
      chk("R9 osc kept", osc_en, 1);
      wake_n = '1;
      tick(3);
      if (use_fiq) fiq = 1; else irq = 1;
      tick(2);
      chk("R9 early", cpu_clk_en, 0);
      tick(1);
      chk("R9 cpu on", cpu_clk_en, 1);
      chk("R7 idle exit", woke_fast, 0);
      irq = 0; fiq = 0;
      tick(3);
   endtask

   task automatic test_priority;
      pulse_cmd(1, 1);
      chk_all("R11", 0, 0, 0, 0);
      wake_n[0] = 0;
      tick(5);
      chk("R11 exit", cpu_clk_en, 1);
      wake_n = '1;
      tick(3);
   endtask

   initial begin
      #(8 * 200000);
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 0; wake_n = '1; wake_en = 16'h0001;
      wait_req = 0; idle_req = 0; irq = 0; fiq = 0; osc_ready = 0;
      tick(3);
      rst_n = 1;
      tick(2);
      test_reset();
      test_combine();
      wake_en = 16'h8001;
      test_run_ignore();
      test_wait_fast();
      test_wait_ignore();
      test_idle(0);
      test_idle(1);
      test_priority();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule